// File: doc/BRIEF.md
# I2C Interrupt and Status Word

This block holds the interrupt and status word of an I2C peripheral and presents it as a 32-bit read value. The protocol engine sends it single-cycle event pulses and a few level signals. The block turns the pulses into sticky flags, follows the level signals, and captures the matched address code and transfer direction. It also raises one interrupt request from the flags that software has enabled.

Software clears sticky flags through write-one-to-clear strobes that come from a separate clear register, one strobe per flag position. A peripheral-enable input and a software-reset input drop the bus-busy flag and the SMBus-class flags. A parameter removes SMBus support, and the alert, timeout and PEC-error flags then read as zero. The SMBus alert pin is asynchronous. It passes through a synchronizer before its falling edges are detected. When a PEC mismatch is flagged, the block also pulses an automatic-NACK request back to the engine.

Top module: `i2cIsrStatus`

## Requirements
- R1: During and after reset the word reads 0x0000_0001, with only the transmit-empty flag (bit 0) set. Bits 31:24 and bit 14 always read 0.
- R2: The sticky flags at bits 10 (overrun), 9 (arbitration lost), 8 (bus error), 5 (STOP seen), 4 (NACK received) and 3 (address matched) go to 1 one cycle after their event pulse and hold. Each one clears one cycle after `clrStrobe` has a 1 at the same bit position. If a set event and its clear strobe arrive in the same cycle, the flag ends at 1.
- R3: The level flags at bits 7 (reload pending), 6 (transfer done), 2 (receive not empty), 1 (transmit interrupt) and 0 (transmit empty) show their input values with one cycle of delay.
- R4: On an address match, bits 23:17 load the address code and bit 16 loads the direction (1 = read, so the slave transmits; 0 = write, so the slave receives). These load in the same cycle as bit 3 is set. Without a match, bits 23:16 hold. For 7-bit addressing the code is `rxAddr[6:0]`.
- R5: For a 10-bit address match, the code is the header 5'b11110 followed by `rxAddr[9:8]`.
- R6: Bus busy (bit 15) sets one cycle after a START pulse. It clears one cycle after a STOP pulse, or whenever `periphEn` is 0 or `swReset` is 1.
- R7: The alert flag (bit 13) sets on a falling edge of `smbAlertN`, but only while `smbHostMode` and `alertEn` are both 1. It is set three cycles after the pin falls. Each edge sets the flag at most once, so a pin that stays low does not set it again after a clear. Clear strobe bit 13 clears it.
- R8: The timeout flag (bit 12) sets on either a timeout pulse or a clock-low timeout pulse. Clear strobe bit 12 clears it.
- R9: The PEC error flag (bit 11) sets one cycle after `pecMismatch`. `autoNack` is 1 for exactly that one cycle. Clear strobe bit 11 clears it.
- R10: While `periphEn` is 0 or `swReset` is 1, bits 13:11 and bit 15 are forced to 0, even when a set event arrives in the same cycle.
- R11: `irq` is 1 exactly when some flag in bits 13:0 is 1 and `irqEnable` has a 1 at the same position.
- R12: With `SMB_SUPPORT` = 0, bits 13:11 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periphEn | input | 1 | Peripheral enable |
| swReset | input | 1 | Software reset request |
| startDet | input | 1 | START condition pulse |
| stopDet | input | 1 | STOP condition pulse |
| addrMatch | input | 1 | Own-address match pulse |
| addrTenBit | input | 1 | The match used 10-bit addressing |
| rxAddr | input | 10 | Received address |
| rxRead | input | 1 | Direction bit of the match, 1 = read |
| nackEv | input | 1 | NACK received pulse |
| busErrEv | input | 1 | Misplaced START/STOP pulse |
| arbLostEv | input | 1 | Arbitration lost pulse |
| overrunEv | input | 1 | Overrun/underrun pulse |
| pecMismatch | input | 1 | Received PEC differs from expected |
| timeoutEv | input | 1 | Bus timeout pulse |
| lowTimeoutEv | input | 1 | Extended clock-low timeout pulse |
| smbAlertN | input | 1 | Asynchronous SMBus alert pin, active low |
| smbHostMode | input | 1 | SMBus host configuration |
| alertEn | input | 1 | Alert detection enable |
| reloadPending | input | 1 | Level: reload transfer complete |
| xferDone | input | 1 | Level: transfer complete |
| rxNotEmpty | input | 1 | Level: receive data available |
| txIntReq | input | 1 | Level: transmit data requested |
| txEmpty | input | 1 | Level: transmit data register empty |
| clrStrobe | input | 14 | Write-one-to-clear pulses, aligned to status bits 13:0 |
| irqEnable | input | 14 | Interrupt enables, aligned to status bits 13:0 |
| statusWord | output | 32 | Status word |
| irq | output | 1 | Interrupt request |
| autoNack | output | 1 | Automatic NACK request to the protocol engine |

## Verification
The assertions assume that every event input is a clean pulse, synchronous to `clk` and 0 while reset is applied. They also assume that `smbAlertN` idles high, so the synchronizer's reset value never looks like a falling edge. The stimulus changes inputs only half a clock after an edge and holds each pulse for exactly one cycle. It drives `rxAddr` and `rxRead` as settled values in the cycle of the match. It moves the alert pin slowly enough that each level lasts several cycles through the synchronizer.

// File: rtl/i2cIsrPkg.sv
package i2cIsrPkg;
  localparam int FLAG_W = 16;
  localparam int CODE_W = 7;
  localparam int ADDR_W = 10;
  localparam int CLR_W  = 14;

  localparam int BIT_TXE     = 0;
  localparam int BIT_TXIS    = 1;
  localparam int BIT_RXNE    = 2;
  localparam int BIT_ADDR    = 3;
  localparam int BIT_NACKF   = 4;
  localparam int BIT_STOPF   = 5;
  localparam int BIT_TC      = 6;
  localparam int BIT_TCR     = 7;
  localparam int BIT_BERR    = 8;
  localparam int BIT_ARLO    = 9;
  localparam int BIT_OVR     = 10;
  localparam int BIT_PECERR  = 11;
  localparam int BIT_TIMEOUT = 12;
  localparam int BIT_ALERT   = 13;
  localparam int BIT_BUSY    = 15;

  // flags that software may clear by writing one
  localparam logic [FLAG_W-1:0] W1C_MASK = 16'h3F38;
  // positions that hold state at all (bit 14 reserved)
  localparam logic [FLAG_W-1:0] USED_MASK = 16'hBFFF;
  localparam logic [FLAG_W-1:0] RESET_MASK = 16'h0001;
  localparam logic [FLAG_W-1:0] SMB_MASK = 16'h3800;

  localparam logic [4:0] TEN_BIT_HDR = 5'b11110;

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
    logic [FLAG_W-1:0] killMask;
    logic              capture;
    logic [CODE_W-1:0] code;
    logic              dir;
    logic              nackReq;
  } isrStrobe_t;
endpackage

// File: rtl/i2cIsrCtrl.sv
module i2cIsrCtrl
  import i2cIsrPkg::*;
#(
  parameter bit SMB_SUPPORT = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periphEn,
  input  logic              swReset,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              addrMatch,
  input  logic              addrTenBit,
  input  logic [ADDR_W-1:0] rxAddr,
  input  logic              rxRead,
  input  logic              nackEv,
  input  logic              busErrEv,
  input  logic              arbLostEv,
  input  logic              overrunEv,
  input  logic              pecMismatch,
  input  logic              timeoutEv,
  input  logic              lowTimeoutEv,
  input  logic              smbAlertN,
  input  logic              smbHostMode,
  input  logic              alertEn,
  input  logic [4:0]        levelIn,
  input  logic [CLR_W-1:0]  clrStrobe,
  output isrStrobe_t        strobe
);
  localparam int LEVEL_N = 5;
  localparam int LEVEL_POS [LEVEL_N] = '{BIT_TXE, BIT_TXIS, BIT_RXNE, BIT_TC, BIT_TCR};

  logic disabled;
  logic alertFall;
  logic smbPecSet, smbToSet, smbAlertSet;
  logic [FLAG_W-1:0] smbKill;

  assign disabled = !periphEn || swReset;

  generate
    if (SMB_SUPPORT) begin : gSmb
      logic [SYNC_STAGES-1:0] alertSync;
      logic alertPrev;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          alertSync <= '1;
          alertPrev <= 1'b1;
        end else begin
          alertSync <= {alertSync[SYNC_STAGES-2:0], smbAlertN};
          alertPrev <= alertSync[SYNC_STAGES-1];
        end
      end
      assign alertFall   = alertPrev && !alertSync[SYNC_STAGES-1];
      assign smbPecSet   = pecMismatch;
      assign smbToSet    = timeoutEv || lowTimeoutEv;
      assign smbAlertSet = alertFall && smbHostMode && alertEn;
      assign smbKill     = disabled ? SMB_MASK : '0;
    end else begin : gNoSmb
      assign alertFall   = 1'b0;
      assign smbPecSet   = 1'b0;
      assign smbToSet    = 1'b0;
      assign smbAlertSet = 1'b0;
      assign smbKill     = SMB_MASK;
    end
  endgenerate

  always_comb begin
    strobe = '0;
    strobe.setMask[BIT_BUSY]    = startDet;
    strobe.setMask[BIT_STOPF]   = stopDet;
    strobe.setMask[BIT_ADDR]    = addrMatch;
    strobe.setMask[BIT_NACKF]   = nackEv;
    strobe.setMask[BIT_BERR]    = busErrEv;
    strobe.setMask[BIT_ARLO]    = arbLostEv;
    strobe.setMask[BIT_OVR]     = overrunEv;
    strobe.setMask[BIT_PECERR]  = smbPecSet;
    strobe.setMask[BIT_TIMEOUT] = smbToSet;
    strobe.setMask[BIT_ALERT]   = smbAlertSet;

    strobe.clrMask = {2'b00, clrStrobe} & W1C_MASK;
    strobe.clrMask[BIT_BUSY] = stopDet;

    for (int i = 0; i < LEVEL_N; i++) begin
      strobe.setMask[LEVEL_POS[i]] = levelIn[i];
      strobe.clrMask[LEVEL_POS[i]] = !levelIn[i];
    end

    strobe.killMask = smbKill;
    strobe.killMask[BIT_BUSY] = disabled;

    strobe.capture = addrMatch;
    strobe.code    = addrTenBit ? {TEN_BIT_HDR, rxAddr[ADDR_W-1:ADDR_W-2]}
                                : rxAddr[CODE_W-1:0];
    strobe.dir     = rxRead;
    strobe.nackReq = smbPecSet && !disabled;
  end
endmodule

// File: rtl/i2cIsrDatapath.sv
module i2cIsrDatapath
  import i2cIsrPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  isrStrobe_t       strobe,
  input  logic [CLR_W-1:0] irqEnable,
  output logic [31:0]      statusWord,
  output logic             irq,
  output logic             autoNack
);
  logic [FLAG_W-1:0] flags, flagsNext;
  logic [CODE_W-1:0] codeReg;
  logic              dirReg;

  always_comb begin
    for (int i = 0; i < FLAG_W; i++) begin
      if (!USED_MASK[i] || strobe.killMask[i]) flagsNext[i] = 1'b0;
      else if (strobe.setMask[i])              flagsNext[i] = 1'b1;
      else if (strobe.clrMask[i])              flagsNext[i] = 1'b0;
      else                                     flagsNext[i] = flags[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags    <= RESET_MASK;
      codeReg  <= '0;
      dirReg   <= 1'b0;
      autoNack <= 1'b0;
    end else begin
      flags    <= flagsNext;
      autoNack <= strobe.nackReq;
      if (strobe.capture) begin
        codeReg <= strobe.code;
        dirReg  <= strobe.dir;
      end
    end
  end

  assign statusWord = {8'h00, codeReg, dirReg, flags};
  assign irq = |(flags[CLR_W-1:0] & irqEnable);
endmodule

// File: rtl/i2cIsrStatus.sv
module i2cIsrStatus
  import i2cIsrPkg::*;
#(
  parameter bit SMB_SUPPORT = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        periphEn,
  input  logic        swReset,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        addrMatch,
  input  logic        addrTenBit,
  input  logic [9:0]  rxAddr,
  input  logic        rxRead,
  input  logic        nackEv,
  input  logic        busErrEv,
  input  logic        arbLostEv,
  input  logic        overrunEv,
  input  logic        pecMismatch,
  input  logic        timeoutEv,
  input  logic        lowTimeoutEv,
  input  logic        smbAlertN,
  input  logic        smbHostMode,
  input  logic        alertEn,
  input  logic        reloadPending,
  input  logic        xferDone,
  input  logic        rxNotEmpty,
  input  logic        txIntReq,
  input  logic        txEmpty,
  input  logic [13:0] clrStrobe,
  input  logic [13:0] irqEnable,
  output logic [31:0] statusWord,
  output logic        irq,
  output logic        autoNack
);
  isrStrobe_t strobe;

  i2cIsrCtrl #(.SMB_SUPPORT(SMB_SUPPORT), .SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .periphEn(periphEn), .swReset(swReset),
    .startDet(startDet), .stopDet(stopDet), .addrMatch(addrMatch),
    .addrTenBit(addrTenBit), .rxAddr(rxAddr), .rxRead(rxRead),
    .nackEv(nackEv), .busErrEv(busErrEv), .arbLostEv(arbLostEv),
    .overrunEv(overrunEv), .pecMismatch(pecMismatch), .timeoutEv(timeoutEv),
    .lowTimeoutEv(lowTimeoutEv), .smbAlertN(smbAlertN),
    .smbHostMode(smbHostMode), .alertEn(alertEn),
    .levelIn({reloadPending, xferDone, rxNotEmpty, txIntReq, txEmpty}),
    .clrStrobe(clrStrobe), .strobe(strobe)
  );

  i2cIsrDatapath dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqEnable(irqEnable),
    .statusWord(statusWord), .irq(irq), .autoNack(autoNack)
  );
endmodule

// File: rtl/i2cIsrStatusChk.sv
module i2cIsrStatusChk #(
  parameter bit SMB_SUPPORT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        periphEn,
  input logic        swReset,
  input logic        startDet,
  input logic        addrMatch,
  input logic        overrunEv,
  input logic        pecMismatch,
  input logic [13:0] irqEnable,
  input logic [31:0] statusWord,
  input logic        irq,
  input logic        autoNack
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[31:24] == 8'h00) && !statusWord[14]);

  // R2
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrunEv |=> statusWord[10]);

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrMatch |=> $stable(statusWord[23:16]));

  // R4
  addr_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |=> statusWord[3]);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && periphEn && !swReset) |=> statusWord[15]);

  // R10
  smb_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!periphEn || swReset) |=> (statusWord[13:11] == 3'b000) && !statusWord[15]);

  // R9
  nack_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoNack |-> statusWord[11]);

  // R9
  nack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoNack |=> !autoNack || $past(pecMismatch));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(statusWord[13:0] & irqEnable) == 0) |-> !irq);

  // R12
  no_smb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !SMB_SUPPORT |-> (statusWord[13:11] == 3'b000));
endmodule

bind i2cIsrStatus i2cIsrStatusChk #(.SMB_SUPPORT(SMB_SUPPORT)) chk (
  .clk(clk), .rstN(rstN), .periphEn(periphEn), .swReset(swReset),
  .startDet(startDet), .addrMatch(addrMatch), .overrunEv(overrunEv),
  .pecMismatch(pecMismatch), .irqEnable(irqEnable), .statusWord(statusWord),
  .irq(irq), .autoNack(autoNack)
);

// File: tb/i2cIsrStatus_test.sv
module i2cIsrStatus_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periphEn = 0, swReset = 0, startDet = 0, stopDet = 0, addrMatch = 0;
  logic addrTenBit = 0, rxRead = 0, nackEv = 0, busErrEv = 0, arbLostEv = 0;
  logic overrunEv = 0, pecMismatch = 0, timeoutEv = 0, lowTimeoutEv = 0;
  logic smbAlertN = 1, smbHostMode = 0, alertEn = 0;
  logic reloadPending = 0, xferDone = 0, rxNotEmpty = 0, txIntReq = 0, txEmpty = 1;
  logic [9:0]  rxAddr = '0;
  logic [13:0] clrStrobe = '0, irqEnable = '0;
  logic [31:0] wordA, wordB;
  logic irqA, irqB, nackA, nackB;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  i2cIsrStatus uut (
    .clk(clk), .rstN(rstN), .periphEn(periphEn), .swReset(swReset),
    .startDet(startDet), .stopDet(stopDet), .addrMatch(addrMatch),
    .addrTenBit(addrTenBit), .rxAddr(rxAddr), .rxRead(rxRead), .nackEv(nackEv),
    .busErrEv(busErrEv), .arbLostEv(arbLostEv), .overrunEv(overrunEv),
    .pecMismatch(pecMismatch), .timeoutEv(timeoutEv), .lowTimeoutEv(lowTimeoutEv),
    .smbAlertN(smbAlertN), .smbHostMode(smbHostMode), .alertEn(alertEn),
    .reloadPending(reloadPending), .xferDone(xferDone), .rxNotEmpty(rxNotEmpty),
    .txIntReq(txIntReq), .txEmpty(txEmpty), .clrStrobe(clrStrobe),
    .irqEnable(irqEnable), .statusWord(wordA), .irq(irqA), .autoNack(nackA)
  );

  i2cIsrStatus #(.SMB_SUPPORT(1'b0)) uutNoSmb (
    .clk(clk), .rstN(rstN), .periphEn(periphEn), .swReset(swReset),
    .startDet(startDet), .stopDet(stopDet), .addrMatch(addrMatch),
    .addrTenBit(addrTenBit), .rxAddr(rxAddr), .rxRead(rxRead), .nackEv(nackEv),
    .busErrEv(busErrEv), .arbLostEv(arbLostEv), .overrunEv(overrunEv),
    .pecMismatch(pecMismatch), .timeoutEv(timeoutEv), .lowTimeoutEv(lowTimeoutEv),
    .smbAlertN(smbAlertN), .smbHostMode(smbHostMode), .alertEn(alertEn),
    .reloadPending(reloadPending), .xferDone(xferDone), .rxNotEmpty(rxNotEmpty),
    .txIntReq(txIntReq), .txEmpty(txEmpty), .clrStrobe(clrStrobe),
    .irqEnable(irqEnable), .statusWord(wordB), .irq(irqB), .autoNack(nackB)
  );

  typedef struct {
    logic [31:0] mask;
    logic [31:0] val;
    bit          chkIrq;
    logic        irqVal;
    bit          chkNack;
    logic        nackVal;
    bit          alt;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  // monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      logic [31:0] w;
      logic ir, nk;
      it = expQ.pop_front();
      w  = it.alt ? wordB : wordA;
      ir = it.alt ? irqB : irqA;
      nk = it.alt ? nackB : nackA;
      checks++;
      if ((w & it.mask) !== it.val) begin
        failures++;
        $display("FAIL %s word actual=%h expected=%h (mask %h)", it.tag, w & it.mask, it.val, it.mask);
      end else if (it.chkIrq && ir !== it.irqVal) begin
        failures++;
        $display("FAIL %s irq actual=%b expected=%b", it.tag, ir, it.irqVal);
      end else if (it.chkNack && nk !== it.nackVal) begin
        failures++;
        $display("FAIL %s autoNack actual=%b expected=%b", it.tag, nk, it.nackVal);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expectW(input logic [31:0] mask, input logic [31:0] val, input string tag,
                         input bit chkIrq = 0, input logic irqVal = 0,
                         input bit chkNack = 0, input logic nackVal = 0, input bit alt = 0);
    expItem_t it;
    it.mask = mask; it.val = val; it.chkIrq = chkIrq; it.irqVal = irqVal;
    it.chkNack = chkNack; it.nackVal = nackVal; it.alt = alt; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset value while held in reset
    expectW(32'hFFFF_FFFF, 32'h0000_0001, "R1 reset word", 1, 0, 1, 0);
    expectW(32'hFFFF_FFFF, 32'h0000_0001, "R1 reset word no-smb", 0, 0, 0, 0, 1);
    rstN = 1'b1;
    tick();
    periphEn = 1'b1;
    tick();

    // R6 busy set by START
    startDet = 1; tick(); startDet = 0;
    expectW(32'h0000_8000, 32'h0000_8000, "R6 busy on start");
    // R6 busy cleared by STOP, R2 STOP flag set
    stopDet = 1; tick(); stopDet = 0;
    expectW(32'h0000_8020, 32'h0000_0020, "R6 R2 stop clears busy sets stopf");

    // R4 7-bit match, read
    rxAddr = 10'h05A; rxRead = 1; addrMatch = 1; tick(); addrMatch = 0;
    expectW(32'h00FF_0008, 32'h00B5_0008, "R4 capture 7-bit read");
    rxAddr = 10'h011; rxRead = 0; tick();
    expectW(32'h00FF_0000, 32'h00B5_0000, "R4 hold without match");

    // R5 10-bit match, write
    rxAddr = 10'h2C5; addrTenBit = 1; rxRead = 0; addrMatch = 1; tick();
    addrMatch = 0; addrTenBit = 0;
    expectW(32'h00FF_0000, 32'h00F4_0000, "R5 ten-bit header code");

    // R2 clear of address flag
    clrStrobe = 14'h0008; tick(); clrStrobe = '0;
    expectW(32'h0000_0008, 32'h0, "R2 w1c clears addr flag");
    // R2 set and clear together: set wins
    overrunEv = 1; clrStrobe = 14'h0400; tick(); overrunEv = 0; clrStrobe = '0;
    expectW(32'h0000_0400, 32'h0000_0400, "R2 set beats clear");
    clrStrobe = 14'h0400; tick(); clrStrobe = '0;
    expectW(32'h0000_0400, 32'h0, "R2 overrun cleared");
    arbLostEv = 1; busErrEv = 1; nackEv = 1; tick();
    arbLostEv = 0; busErrEv = 0; nackEv = 0;
    expectW(32'h0000_0310, 32'h0000_0310, "R2 arlo berr nackf set");

    // R3 level flags
    txEmpty = 0; rxNotEmpty = 1; xferDone = 1; tick();
    expectW(32'h0000_00C7, 32'h0000_0044, "R3 levels tracked");
    reloadPending = 1; txIntReq = 1; xferDone = 0; tick();
    expectW(32'h0000_00C7, 32'h0000_0086, "R3 levels retracked");

    // R8 timeout sources
    lowTimeoutEv = 1; tick(); lowTimeoutEv = 0;
    expectW(32'h0000_1000, 32'h0000_1000, "R8 clock-low timeout");
    clrStrobe = 14'h1000; tick(); clrStrobe = '0;
    expectW(32'h0000_1000, 32'h0, "R8 timeout cleared");
    timeoutEv = 1; tick(); timeoutEv = 0;
    expectW(32'h0000_1000, 32'h0000_1000, "R8 bus timeout");

    // R9 PEC error and automatic NACK pulse
    pecMismatch = 1; tick(); pecMismatch = 0;
    expectW(32'h0000_0800, 32'h0000_0800, "R9 pec flag with nack", 0, 0, 1, 1);
    expectW(32'h0000_0800, 32'h0000_0800, "R9 nack one cycle only", 0, 0, 1, 0);

    // R12 no-SMB instance saw the same events
    expectW(32'h0000_3800, 32'h0, "R12 smb flags tied off", 0, 0, 1, 0, 1);

    // R7 alert gated by host mode
    alertEn = 1; smbHostMode = 0; smbAlertN = 0;
    tick(); tick(); tick();
    expectW(32'h0000_2000, 32'h0, "R7 alert ignored without host mode");
    smbAlertN = 1; tick(); tick(); tick();
    smbHostMode = 1; smbAlertN = 0;
    tick(); tick(); tick();
    expectW(32'h0000_2000, 32'h0000_2000, "R7 alert on falling edge");
    clrStrobe = 14'h2000; tick(); clrStrobe = '0;
    tick(); tick(); tick();
    expectW(32'h0000_2000, 32'h0, "R7 held-low pin does not reset flag");

    // R11 interrupt enable gating
    irqEnable = 14'h0800;
    expectW(32'h0000_0800, 32'h0000_0800, "R11 irq from enabled pec flag", 1, 1);
    irqEnable = 14'h2000;
    expectW(32'h0000_2000, 32'h0, "R11 irq quiet when enabled flag clear", 1, 0);
    irqEnable = '0;

    // R10 software reset kills busy and smb flags
    startDet = 1; tick(); startDet = 0;
    expectW(32'h0000_F800, 32'h0000_9800, "R10 pre-reset flags");
    swReset = 1; timeoutEv = 1; tick(); swReset = 0; timeoutEv = 0;
    expectW(32'h0000_B800, 32'h0, "R10 swReset clears busy and smb flags");
    // R10 disable overrides a set event
    periphEn = 0; timeoutEv = 1; startDet = 1; tick(); timeoutEv = 0; startDet = 0;
    expectW(32'h0000_9000, 32'h0, "R10 disabled blocks timeout and busy");
    periphEn = 1;
    // R1 reserved bits still zero
    expectW(32'hFF00_4000, 32'h0, "R1 reserved bits");

    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule